// File: doc/BRIEF.md
# I2C Register Target with Read Auto-Increment

This block lets a host on a two-wire I2C bus reach a bank of 8-bit control and telemetry registers. It runs from a system clock. It oversamples both bus lines and filters them, then detects START and STOP conditions. It matches its own 7-bit address and acknowledges each byte it accepts. A host sends a telecommand as a register-pointer byte followed by a value byte. The value byte produces a single-cycle write strobe toward the register file.

To read, the host first sets the pointer in a short write transfer. It then issues a read transfer. The block returns the selected register, most significant bit first. After each byte it sends, the pointer advances by one, so back-to-back read bytes walk through consecutive registers. The register file itself sits outside this block. The block presents an address on a read port and takes the returned byte combinationally, so live telemetry inputs can sit behind that port. Pointer values beyond the implemented register count read as zero and never strobe a write. The block does not hold SCL low to stretch the clock, does not arbitrate between several hosts, and does not accept 10-bit addressing.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges (drives SDA low during the ninth clock) a header whose upper seven bits equal the parameter TGT_ADDR (default 0x26). A header with any other address is not acknowledged, and every byte after it is ignored until the next START.
- R2: In a write transfer, the first byte after the header loads the 8-bit register pointer and produces no write strobe.
- R3: In a write transfer, the second byte after the header produces exactly one single-cycle `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to that byte.
- R4: Further bytes in the same write transfer are acknowledged but produce no strobe and leave the pointer unchanged.
- R5: A read transfer returns the register that the pointer selects, MSB first, and SDA changes only while SCL is low.
- R6: The pointer increments by one after each transmitted read byte, wrapping from 0xFF to 0x00. A later read transfer that does not reload the pointer continues from where the previous read stopped.
- R7: A pointer at or above NUM_REGS (default 16) reads as 0x00 and produces no write strobe.
- R8: When the host answers a read byte with NACK, the block releases SDA and sends nothing further until the next START.
- R9: Each bus line is passed through a two-stage synchroniser and then needs two equal consecutive samples before its filtered value changes. A pulse that lasts a single system clock creates no bit, no START and no STOP.
- R10: A repeated START returns the block to the address phase and restarts the byte count of the write transfer, while the pointer keeps its value. A STOP releases SDA.
- R11: Out of reset the block does not drive SDA and `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain driver enable) |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | AW | Register index for the write strobe |
| wr_data | output | 8 | Value to write |
| rd_addr | output | AW | Register index whose value is wanted on rd_data |
| rd_data | input | 8 | Combinational read value from the register file |

## Verification
A wrong pointer shows up on the very next read byte. It appears as a value taken from the wrong register, or as a nonzero value where an out-of-range zero was expected. A sweep that reads every register in one burst exposes a skipped or repeated increment within one byte time. A wrong byte count shows up as a missing strobe, an extra strobe or a write to the wrong index, which the bench's register model reveals after the transfer ends. A filter or edge-detection fault corrupts a received bit or fakes a STOP. The write then lands as the wrong value or is not acknowledged at all.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } tgt_state_e;

   // Position of a received byte inside a write transfer.
   typedef enum logic [1:0] {
      WB_PTR,
      WB_DATA,
      WB_EXTRA
   } wr_byte_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   localparam int TOP = SYNC_STAGES;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("i2c_line_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '1;
         filt_o <= 1'b1;
      end else begin
         pipe_q <= {pipe_q[TOP-1:0], raw_i};
         if (pipe_q[TOP] == pipe_q[TOP-1])
            filt_o <= pipe_q[TOP];
      end
   end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_p  = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_p   = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h26,
   parameter int         NUM_REGS = 16,
   localparam int        AW = $clog2(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_f,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_p,
   input  logic          stop_p,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [AW-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data
);
   tgt_state_e           state_q;
   wr_byte_e             wb_q;
   logic [BIT_CNT_W-1:0] cnt_q;
   logic [BYTE_W-1:0]    rx_q, tx_q, ptr_q, rd_val;
   logic                 rw_q, host_ack_q, in_range;

   generate
      if ((1 << AW) == NUM_REGS) begin : g_pow2
         assign in_range = ((ptr_q >> AW) == '0);
      end else begin : g_cmp
         assign in_range = (int'(ptr_q) < NUM_REGS);
      end
   endgenerate

   assign rd_val  = in_range ? rd_data : '0;
   assign rd_addr = ptr_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         wb_q       <= WB_PTR;
         cnt_q      <= '0;
         rx_q       <= '0;
         tx_q       <= '0;
         ptr_q      <= '0;
         rw_q       <= 1'b0;
         host_ack_q <= 1'b0;
         sda_oe     <= 1'b0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_p) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            wb_q    <= WB_PTR;
            sda_oe  <= 1'b0;
         end else if (stop_p) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: sda_oe <= 1'b0;
               ST_ADDR: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[BYTE_W-2:0], sda_f};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == BIT_CNT_W'(BYTE_W)) begin
                     if (rx_q[7:1] == TGT_ADDR) begin
                        sda_oe  <= 1'b1;
                        rw_q    <= rx_q[0];
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        tx_q    <= rd_val;
                        sda_oe  <= ~rd_val[BYTE_W-1];
                        cnt_q   <= BIT_CNT_W'(1);
                        state_q <= ST_RD;
                     end else begin
                        sda_oe  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[BYTE_W-2:0], sda_f};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == BIT_CNT_W'(BYTE_W)) begin
                     sda_oe  <= 1'b1;
                     state_q <= ST_WR_ACK;
                     unique case (wb_q)
                        WB_PTR: begin
                           ptr_q <= rx_q;
                           wb_q  <= WB_DATA;
                        end
                        WB_DATA: begin
                           wr_en   <= in_range;
                           wr_addr <= ptr_q[AW-1:0];
                           wr_data <= rx_q;
                           wb_q    <= WB_EXTRA;
                        end
                        default: wb_q <= WB_EXTRA;
                     endcase
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     cnt_q   <= '0;
                     state_q <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt_q == BIT_CNT_W'(BYTE_W)) begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_RD_ACK;
                     end else begin
                        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_q[BYTE_W-2];
                        cnt_q  <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     host_ack_q <= ~sda_f;
                     ptr_q      <= ptr_q + 1'b1;
                  end else if (scl_fall) begin
                     if (host_ack_q) begin
                        tx_q    <= rd_val;
                        sda_oe  <= ~rd_val[BYTE_W-1];
                        cnt_q   <= BIT_CNT_W'(1);
                        state_q <= ST_RD;
                     end else begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
   parameter logic [6:0] TGT_ADDR    = 7'h26,
   parameter int         NUM_REGS    = 16,
   parameter int         SYNC_STAGES = 2,
   localparam int        AW = $clog2(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data
);
   generate
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_regs
         $error("i2c_reg_target: NUM_REGS must lie in 2..256");
      end
   endgenerate

   localparam int LINES = 2;  // index 0 = SCL, index 1 = SDA

   logic [LINES-1:0] raw, filt;
   logic scl_f, sda_f, scl_rise, scl_fall, start_p, stop_p;

   assign raw = {sda_i, scl_i};

   for (genvar i = 0; i < LINES; i++) begin : g_line
      i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
         .clk(clk), .rst_n(rst_n), .raw_i(raw[i]), .filt_o(filt[i])
      );
   end

   assign scl_f = filt[0];
   assign sda_f = filt[1];

   i2c_bus_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p)
   );

   i2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p),
      .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic scl_f,
   input logic stop_p,
   input logic sda_oe,
   input logic wr_en
);
   // R3: the write strobe never lasts longer than one cycle
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R5: the target only starts pulling SDA while filtered SCL is low
   a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_f);

   // R9: a filtered rising edge needs two high samples behind the synchroniser
   a_r9_rise_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_f) |-> ($past(scl_i, 3) && $past(scl_i, 4)));

   // R9: same rule for a falling edge
   a_r9_fall_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_f) |-> (!$past(scl_i, 3) && !$past(scl_i, 4)));

   // R10: a STOP leaves SDA released
   a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_f(scl_f),
   .stop_p(stop_p), .sda_oe(sda_oe), .wr_en(wr_en)
);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
   localparam int NREG = 16;
   localparam int AW   = 4;
   localparam int Q    = 8;          // system clocks per quarter bit
   localparam logic [6:0] ADDR = 7'h26;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1, sda_h = 1'b1;
   logic sda_oe, wr_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   logic sda_bus;
   logic glitch = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_h & ~sda_oe;

   i2c_reg_target dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
      .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // register file model
   logic [7:0] mem [NREG];
   int strobes = 0;
   assign rd_data = mem[rd_addr];
   always @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
         strobes <= strobes + 1;
      end
   end

   logic [7:0] expv [NREG];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp_v);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
   endtask

   task automatic clk_bit(input logic b, output logic r);
      sda_h = b;
      if (glitch) begin
         @(negedge clk) scl_h = 1'b1;
         @(negedge clk) scl_h = 1'b0;
      end
      wq(); scl_h = 1'b1; wq();
      if (glitch && b) begin
         @(negedge clk) sda_h = 1'b0;
         @(negedge clk) sda_h = 1'b1;
      end
      r = sda_bus; wq(); scl_h = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
      clk_bit(1'b1, r);
      acked = ~r;
   endtask

   task automatic recv_byte(input logic host_ack, output logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, r);
         b[i] = r;
      end
      clk_bit(~host_ack, r);
   endtask

   task automatic wr_xfer(input logic [7:0] p, input logic [7:0] v);
      logic a;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(p, a);
      send_byte(v, a);
      bus_stop();
      if (int'(p) < NREG) expv[p] = v;
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) & 8'hff);
   endfunction

   initial begin
      logic a;
      logic [7:0] b;
      int s0;
      for (int i = 0; i < NREG; i++) begin
         mem[i] = 8'h00;
         expv[i] = 8'h00;
      end
      repeat (5) @(negedge clk);
      // R11: reset state
      chk("R11 sda released in reset", int'(sda_oe), 0);
      chk("R11 wr_en low in reset", int'(wr_en), 0);
      rst_n = 1'b1;
      wq();

      // R1/R2/R3: basic pointer + value write
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R1 header ack", int'(a), 1);
      send_byte(8'h03, a);        chk("R2 pointer byte ack", int'(a), 1);
      chk("R2 no strobe on pointer byte", strobes, 0);
      send_byte(8'hA5, a);        chk("R3 data byte ack", int'(a), 1);
      bus_stop();
      expv[3] = 8'hA5;
      chk("R3 one strobe", strobes, 1);
      chk("R3 register written", int'(mem[3]), 'hA5);

      // R4: extra bytes ignored, pointer unchanged
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h05, a);
      send_byte(8'h11, a);
      send_byte(8'h22, a); chk("R4 extra byte acked", int'(a), 1);
      send_byte(8'h33, a);
      bus_stop();
      expv[5] = 8'h11;
      chk("R4 single strobe", strobes, 2);
      chk("R4 next register untouched", int'(mem[6]), 0);
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R4 pointer kept after extras", int'(b), 'h11);

      // R5/R6/R7: fill all registers, then one burst read
      for (int i = 0; i < NREG; i++) wr_xfer(8'(i), pat(i));
      for (int i = 0; i < NREG; i++)
         chk("R3 sweep write", int'(mem[i]), int'(expv[i]));
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h00, a);
      bus_start();
      send_byte({ADDR, 1'b1}, a); chk("R1 read header ack", int'(a), 1);
      for (int i = 0; i < NREG; i++) begin
         recv_byte(1'b1, b);
         chk("R6 burst read", int'(b), int'(expv[i]));
      end
      recv_byte(1'b0, b);
      chk("R7 out of range reads zero", int'(b), 0);
      // R8: after NACK the bus stays released
      wq();
      chk("R8 sda released after nack", int'(sda_bus), 1);
      bus_stop();
      // R6: a new read continues from NREG+1 (still out of range)
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R6 continue past last read", int'(b), 0);

      // R6: wrap 0xFF -> 0x00
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'hFF, a);
      bus_stop();
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b1, b); chk("R7 read at 0xFF", int'(b), 0);
      recv_byte(1'b0, b); chk("R6 wrap to register 0", int'(b), int'(expv[0]));
      bus_stop();

      // R7: out-of-range write gives no strobe
      s0 = strobes;
      wr_xfer(8'h20, 8'h77);
      chk("R7 no strobe out of range", strobes, s0);

      // R1: foreign address is not acknowledged and its bytes are ignored
      bus_start();
      send_byte({7'h27, 1'b0}, a); chk("R1 foreign nack", int'(a), 0);
      send_byte(8'h02, a);
      send_byte(8'h99, a);
      bus_stop();
      chk("R1 foreign bytes ignored", strobes, s0);
      chk("R1 register intact", int'(mem[2]), int'(expv[2]));

      // R10: repeated START restarts the byte count
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h07, a);
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h08, a);
      send_byte(8'h3C, a);
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b0, b);
      bus_stop();
      expv[8] = 8'h3C;
      chk("R10 write after repeated start", int'(mem[8]), 'h3C);
      chk("R10 first pointer untouched", int'(mem[7]), int'(expv[7]));
      chk("R10 read back", int'(b), 'h3C);

      // R9: single-clock glitches on both lines
      glitch = 1'b1;
      s0 = strobes;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R9 header ack under glitches", int'(a), 1);
      send_byte(8'h0A, a);
      send_byte(8'h6B, a);
      bus_stop();
      glitch = 1'b0;
      chk("R9 one strobe under glitches", strobes, s0 + 1);
      chk("R9 value under glitches", int'(mem[10]), 'h6B);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule